// File: doc/BRIEF.md
# Timer Interrupt Router

This block sits behind a bank of hardware timers and turns each timer's one-cycle fire pulse into an interrupt. Every timer owns a small configuration word held in the block. That word chooses one of three deliveries: a message write whose address and data come from a per-timer route register, a one-cycle pulse on one of 32 interrupt lines, or a level on such a line that stays up until software acknowledges it. Level assertions are recorded in a status vector. Software clears entries in that vector by writing ones to them.

The block also enforces which lines a timer may use. A configuration write that names a line outside the permitted set is stored as route 0, and route 0 means the timer is not connected to any line. When a reconfiguration makes a held level meaningless, the block drops it by itself. Each timer runs a three-state machine. In `ST_IDLE` an accepted fire can take one of three transitions: *queue* to `ST_PEND` for message delivery, *latch* to `ST_HELD` for level delivery, or *pulse*, which stays in `ST_IDLE` and emits an edge. `ST_HELD` leaves through *release* when a status clear or a reconfiguration drops the level. `ST_PEND` leaves through *issue* when the message arbiter grants it.

Top module: `timer_irq_router`

## Requirements
- R1: A fire pulse has no effect when the timer's enable bit (config bit 2) is 0: no line, no status and no message.
- R2: When config bit 14 (message enable) is set and the message capability parameter is 1, a fire sampled at clock edge k raises `msg_req_o` for one cycle after edge k+1. `msg_addr_o` carries route register bits 63:32, `msg_data_o` carries bits 31:0, and no line is driven.
- R3: When several timers have messages waiting, they are issued one per cycle, lowest timer index first.
- R4: The route field is config bits 13:9. A value of 0 means unrouted, so a line-delivered fire is dropped and leaves no status.
- R5: A config write whose route is nonzero and not in the permitted mask is stored as route 0. The mask is lines 24..31 when LINE_COUNT is 32 or more, lines LINE_COUNT-4..LINE_COUNT-1 when LINE_COUNT is 20..31, and empty otherwise. With the default of 24 this is lines 20..23.
- R6: With config bit 1 at 0 (edge), a fire sampled at edge k drives the routed line high for exactly the cycle after edge k and leaves status unchanged.
- R7: With config bit 1 at 1 (level), a fire sets the timer's status bit and holds the routed line high until the level is released.
- R8: A fire has no effect while the timer's status bit is set. A fire in the same cycle as a status clear of that bit leaves the bit clear.
- R9: A status write clears exactly the bits written as 1 that are currently set. Bits written as 0 stay as they are, and writing 1 to a clear bit does not set it.
- R10: A config write to a timer with a set status bit releases it on the next edge when the new word disables the interrupt, selects edge mode, selects message delivery, or changes the route. A write that changes none of these keeps the level.
- R11: When several timers hold levels on the same line, the line stays high until the last of them is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fire_i | input | N_TIMERS | One-cycle fire pulse per timer |
| cfg_we_i | input | 1 | Config write strobe |
| cfg_idx_i | input | IDX_W | Timer addressed by the config write |
| cfg_wdata_i | input | 16 | Writable low half of the config word |
| msg_route_i | input | 64*N_TIMERS | Per-timer message address (63:32) and data (31:0) |
| stat_clr_we_i | input | 1 | Status clear strobe |
| stat_clr_i | input | N_TIMERS | Write-one-to-clear status mask |
| irq_lines_o | output | 32 | Interrupt line vector |
| status_o | output | N_TIMERS | Level status per timer |
| msg_req_o | output | 1 | One-cycle message request |
| msg_addr_o | output | 32 | Message address |
| msg_data_o | output | 32 | Message data |

## Verification
If a timer's state machine is stuck in `ST_HELD`, the fault shows on `status_o` and on its line, and it is visible one edge after the clear or reconfiguration that should have released it. A timer wrongly left in `ST_PEND` shows as a missing or duplicated `msg_req_o` two edges after its fire. Any such timer also ignores every later fire, so the next stimulus exposes it as well. A wrong stored route is not visible until the next fire, and then it appears on the very next cycle as a line on the wrong bit.

// File: rtl/tir_pkg.sv
package tir_pkg;

    localparam int LINE_W     = 32;
    localparam int ROUTE_W    = 5;
    localparam int WORD_W     = 64;
    localparam int B_LEVEL    = 1;
    localparam int B_IEN      = 2;
    localparam int B_ROUTE_LO = 9;
    localparam int B_MSG_EN   = 14;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HELD = 2'd1,
        ST_PEND = 2'd2
    } tmr_state_e;

    typedef struct packed {
        logic               msg_en;
        logic [ROUTE_W-1:0] route;
        logic               ien;
        logic               level;
    } tmr_cfg_t;

    function automatic logic [LINE_W-1:0] permit_mask(input int line_count);
        if (line_count >= 32)
            return 32'hff00_0000;
        else if (line_count >= 20)
            return 32'hf << (line_count - 4);
        else
            return '0;
    endfunction

endpackage

// File: rtl/tir_cfg_bank.sv
module tir_cfg_bank
    import tir_pkg::*;
#(
    parameter int N_TIMERS   = 8,
    parameter int LINE_COUNT = 24,
    parameter bit MSG_CAP    = 1'b1,
    parameter int IDX_W      = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we_i,
    input  logic [IDX_W-1:0]         idx_i,
    input  logic [15:0]              wdata_i,
    output tmr_cfg_t [N_TIMERS-1:0]  cfg_o,
    output logic [N_TIMERS-1:0]      msg_o,
    output logic [N_TIMERS-1:0]      kill_o
);

    localparam logic [LINE_W-1:0] PERMIT = permit_mask(LINE_COUNT);

    tmr_cfg_t [N_TIMERS-1:0] cfg_q;
    tmr_cfg_t                wr_cfg;

    // Decode and sanitise the incoming word
    always_comb begin
        wr_cfg.level  = wdata_i[B_LEVEL];
        wr_cfg.ien    = wdata_i[B_IEN];
        wr_cfg.msg_en = wdata_i[B_MSG_EN];
        wr_cfg.route  = wdata_i[B_ROUTE_LO +: ROUTE_W];
        if (wr_cfg.route != '0 && !PERMIT[wr_cfg.route])
            wr_cfg.route = '0;
    end

    generate
        for (genvar t = 0; t < N_TIMERS; t++) begin : g_cfg
            logic hit;
            assign hit = we_i && (idx_i == IDX_W'(t));

            always_ff @(posedge clk) begin
                if (!rst_n)
                    cfg_q[t] <= '0;
                else if (hit)
                    cfg_q[t] <= wr_cfg;
            end

            assign kill_o[t] = hit && (!wr_cfg.ien || (wr_cfg.msg_en && MSG_CAP) ||
                                       !wr_cfg.level || (wr_cfg.route != cfg_q[t].route));
            assign msg_o[t]  = cfg_q[t].msg_en && MSG_CAP;
        end
    endgenerate

    assign cfg_o = cfg_q;

endmodule

// File: rtl/tir_timer_fsm.sv
module tir_timer_fsm
    import tir_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     fire_i,
    input  logic     ien_i,
    input  tmr_cfg_t cfg_i,
    input  logic     msg_i,
    input  logic     kill_i,
    input  logic     clr_i,
    input  logic     grant_i,
    output logic     held_o,
    output logic     pend_o,
    output logic     pulse_o
);

    tmr_state_e state_q, state_d;
    logic       pulse_q, pulse_d;
    logic       accept;

    assign accept = fire_i && ien_i;

    always_comb begin
        state_d = state_q;
        pulse_d = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (msg_i)
                        state_d = ST_PEND;          // queue
                    else if (cfg_i.route != '0) begin
                        if (cfg_i.level)
                            state_d = ST_HELD;      // latch
                        else
                            pulse_d = 1'b1;         // pulse
                    end
                end
            end
            ST_HELD: begin
                if (clr_i || kill_i)
                    state_d = ST_IDLE;              // release
            end
            ST_PEND: begin
                if (grant_i)
                    state_d = ST_IDLE;              // issue
            end
            default: state_d = ST_IDLE;
        endcase
        if (kill_i && state_d == ST_HELD)
            state_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pulse_q <= 1'b0;
        end else begin
            state_q <= state_d;
            pulse_q <= pulse_d;
        end
    end

    always_comb begin
        held_o  = (state_q == ST_HELD);
        pend_o  = (state_q == ST_PEND);
        pulse_o = pulse_q;
    end

endmodule

// File: rtl/tir_msg_arb.sv
module tir_msg_arb
    import tir_pkg::*;
#(
    parameter int N_TIMERS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_TIMERS-1:0]          pend_i,
    input  logic [N_TIMERS*WORD_W-1:0]   route_i,
    output logic [N_TIMERS-1:0]          grant_o,
    output logic                         req_o,
    output logic [31:0]                  addr_o,
    output logic [31:0]                  data_o
);

    logic              found;
    logic [WORD_W-1:0] sel;

    always_comb begin
        grant_o = '0;
        found   = 1'b0;
        sel     = '0;
        for (int t = 0; t < N_TIMERS; t++) begin
            if (pend_i[t] && !found) begin
                grant_o[t] = 1'b1;
                found      = 1'b1;
                sel        = route_i[t*WORD_W +: WORD_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_o  <= 1'b0;
            addr_o <= '0;
            data_o <= '0;
        end else begin
            req_o  <= found;
            addr_o <= sel[63:32];
            data_o <= sel[31:0];
        end
    end

endmodule

// File: rtl/timer_irq_router.sv
module timer_irq_router
    import tir_pkg::*;
#(
    parameter int N_TIMERS   = 8,
    parameter int LINE_COUNT = 24,
    parameter bit MSG_CAP    = 1'b1,
    localparam int IDX_W     = (N_TIMERS > 1) ? $clog2(N_TIMERS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_TIMERS-1:0]           fire_i,
    input  logic                          cfg_we_i,
    input  logic [IDX_W-1:0]              cfg_idx_i,
    input  logic [15:0]                   cfg_wdata_i,
    input  logic [N_TIMERS*WORD_W-1:0]    msg_route_i,
    input  logic                          stat_clr_we_i,
    input  logic [N_TIMERS-1:0]           stat_clr_i,
    output logic [LINE_W-1:0]             irq_lines_o,
    output logic [N_TIMERS-1:0]           status_o,
    output logic                          msg_req_o,
    output logic [31:0]                   msg_addr_o,
    output logic [31:0]                   msg_data_o
);

    tmr_cfg_t [N_TIMERS-1:0] cfg;
    logic [N_TIMERS-1:0]     msg, kill, held, pend, pulse, grant, ien_vec;

    tir_cfg_bank #(
        .N_TIMERS  (N_TIMERS),
        .LINE_COUNT(LINE_COUNT),
        .MSG_CAP   (MSG_CAP),
        .IDX_W     (IDX_W)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (cfg_we_i),
        .idx_i  (cfg_idx_i),
        .wdata_i(cfg_wdata_i),
        .cfg_o  (cfg),
        .msg_o  (msg),
        .kill_o (kill)
    );

    generate
        for (genvar t = 0; t < N_TIMERS; t++) begin : g_tmr
            assign ien_vec[t] = cfg[t].ien;

            tir_timer_fsm u_fsm (
                .clk    (clk),
                .rst_n  (rst_n),
                .fire_i (fire_i[t]),
                .ien_i  (ien_vec[t]),
                .cfg_i  (cfg[t]),
                .msg_i  (msg[t]),
                .kill_i (kill[t]),
                .clr_i  (stat_clr_we_i && stat_clr_i[t]),
                .grant_i(grant[t]),
                .held_o (held[t]),
                .pend_o (pend[t]),
                .pulse_o(pulse[t])
            );
        end
    endgenerate

    tir_msg_arb #(.N_TIMERS(N_TIMERS)) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pend),
        .route_i(msg_route_i),
        .grant_o(grant),
        .req_o  (msg_req_o),
        .addr_o (msg_addr_o),
        .data_o (msg_data_o)
    );

    // Line vector: OR of every timer's level or pulse on its route
    always_comb begin
        irq_lines_o = '0;
        for (int t = 0; t < N_TIMERS; t++) begin
            for (int l = 1; l < LINE_W; l++) begin
                if ((held[t] || pulse[t]) && cfg[t].route == ROUTE_W'(l))
                    irq_lines_o[l] = 1'b1;
            end
        end
    end

    assign status_o = held;

endmodule

// File: rtl/tir_checker.sv
module tir_checker
    import tir_pkg::*;
#(
    parameter int N_TIMERS = 8,
    parameter int IDX_W    = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic [N_TIMERS-1:0] fire_i,
    input logic [N_TIMERS-1:0] ien_i,
    input logic                cfg_we_i,
    input logic [IDX_W-1:0]    cfg_idx_i,
    input logic [15:0]         cfg_wdata_i,
    input logic                stat_clr_we_i,
    input logic [N_TIMERS-1:0] stat_clr_i,
    input logic [N_TIMERS-1:0] status_o
);

    generate
        for (genvar t = 0; t < N_TIMERS; t++) begin : g_chk
            AST_FIRE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
                fire_i[t] && !ien_i[t] && !status_o[t] |=> !status_o[t]); // R1

            AST_STATUS_FROM_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(status_o[t]) |-> $past(fire_i[t])); // R7

            AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                status_o[t] && !stat_clr_we_i && !cfg_we_i |=> status_o[t]); // R7

            AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                stat_clr_we_i && stat_clr_i[t] && status_o[t] |=> !status_o[t]); // R9

            AST_DISABLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
                cfg_we_i && cfg_idx_i == IDX_W'(t) && !cfg_wdata_i[B_IEN] |=> !status_o[t]); // R10
        end
    endgenerate

endmodule

bind timer_irq_router tir_checker #(.N_TIMERS(N_TIMERS), .IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fire_i       (fire_i),
    .ien_i        (ien_vec),
    .cfg_we_i     (cfg_we_i),
    .cfg_idx_i    (cfg_idx_i),
    .cfg_wdata_i  (cfg_wdata_i),
    .stat_clr_we_i(stat_clr_we_i),
    .stat_clr_i   (stat_clr_i),
    .status_o     (status_o)
);

// File: tb/timer_irq_router_bench.sv
`timescale 1ns/1ps
module timer_irq_router_bench;

    localparam int N = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  fire = '0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_idx = '0;
    logic [15:0]   cfg_wdata = '0;
    logic [N*64-1:0] route = '0;
    logic          clr_we = 1'b0;
    logic [N-1:0]  clr = '0;
    logic [31:0]   lines, w_lines;
    logic [N-1:0]  status, w_status;
    logic          mreq, w_mreq;
    logic [31:0]   maddr, mdata, w_maddr, w_mdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    timer_irq_router u_timer_irq_router (
        .clk(clk), .rst_n(rst_n), .fire_i(fire), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx),
        .cfg_wdata_i(cfg_wdata), .msg_route_i(route), .stat_clr_we_i(clr_we), .stat_clr_i(clr),
        .irq_lines_o(lines), .status_o(status), .msg_req_o(mreq), .msg_addr_o(maddr),
        .msg_data_o(mdata));

    timer_irq_router #(.LINE_COUNT(32)) u_wide (
        .clk(clk), .rst_n(rst_n), .fire_i(fire), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx),
        .cfg_wdata_i(cfg_wdata), .msg_route_i(route), .stat_clr_we_i(clr_we), .stat_clr_i(clr),
        .irq_lines_o(w_lines), .status_o(w_status), .msg_req_o(w_mreq), .msg_addr_o(w_maddr),
        .msg_data_o(w_mdata));

    // {msg_en, ien, level, route[5], exp_line[5], exp_held, exp_msg, req[4]}
    localparam logic [18:0] TBL [10] = '{
        {1'b0, 1'b1, 1'b1, 5'd21, 5'd21, 1'b1, 1'b0, 4'd7},  // R7 level
        {1'b0, 1'b1, 1'b0, 5'd22, 5'd22, 1'b0, 1'b0, 4'd6},  // R6 edge
        {1'b0, 1'b0, 1'b1, 5'd21, 5'd0,  1'b0, 1'b0, 4'd1},  // R1 disabled
        {1'b0, 1'b1, 1'b1, 5'd5,  5'd0,  1'b0, 1'b0, 4'd5},  // R5 illegal
        {1'b1, 1'b1, 1'b1, 5'd21, 5'd0,  1'b0, 1'b1, 4'd2},  // R2 message
        {1'b0, 1'b1, 1'b0, 5'd0,  5'd0,  1'b0, 1'b0, 4'd4},  // R4 unrouted
        {1'b0, 1'b1, 1'b1, 5'd23, 5'd23, 1'b1, 1'b0, 4'd7},  // R7 top permitted
        {1'b0, 1'b1, 1'b1, 5'd20, 5'd20, 1'b1, 1'b0, 4'd5},  // R5 lowest permitted
        {1'b0, 1'b1, 1'b1, 5'd24, 5'd0,  1'b0, 1'b0, 4'd5},  // R5 above mask
        {1'b0, 1'b1, 1'b1, 5'd19, 5'd0,  1'b0, 1'b0, 4'd5}   // R5 below mask
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [15:0] mk(input bit m, input bit ien, input bit lvl, input logic [4:0] r);
        logic [15:0] w;
        w = '0;
        w[14] = m;
        w[2] = ien;
        w[1] = lvl;
        w[13:9] = r;
        return w;
    endfunction

    task automatic wcfg(input int idx, input logic [15:0] w);
        cfg_we = 1'b1;
        cfg_idx = 3'(idx);
        cfg_wdata = w;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic pulse_fire(input logic [N-1:0] m);
        fire = m;
        tick();
        fire = '0;
    endtask

    task automatic wclr(input logic [N-1:0] m);
        clr_we = 1'b1;
        clr = m;
        tick();
        clr_we = 1'b0;
        clr = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        route[0*64 +: 64] = {32'hfee0_1000, 32'h0000_0041};
        route[2*64 +: 64] = {32'hfee0_2000, 32'h0000_0052};
        repeat (3) tick();
        // reset state
        chk("reset lines", 64'(lines), 64'h0);
        chk("reset status", 64'(status), 64'h0);
        chk("reset msg", 64'(mreq), 64'h0);
        rst_n = 1'b1;
        tick();

        for (int i = 0; i < 10; i++) begin
            logic [18:0] e;
            logic [31:0] exp_l;
            string tag;
            e = TBL[i];
            tag = $sformatf("R%0d entry %0d", e[3:0], i);
            exp_l = (e[10:6] == 5'd0) ? 32'h0 : (32'h1 << e[10:6]);
            wcfg(0, mk(e[18], e[17], e[16], e[15:11]));
            pulse_fire(8'h01);
            chk({tag, " lines"}, 64'(lines), 64'(exp_l));
            chk({tag, " status"}, 64'(status[0]), 64'(e[5]));
            tick();
            chk({tag, " lines later"}, 64'(lines), e[5] ? 64'(exp_l) : 64'h0);
            chk({tag, " msg"}, 64'(mreq), 64'(e[4]));
            if (e[4]) begin
                chk({tag, " addr"}, 64'(maddr), 64'h fee0_1000);
                chk({tag, " data"}, 64'(mdata), 64'h41);
            end
            wclr('1);
            chk({tag, " cleared"}, 64'(lines), 64'h0);
        end

        // R8: fire together with clear of the held bit
        wcfg(0, mk(0, 1, 1, 5'd21));
        pulse_fire(8'h01);
        chk("R8 held", 64'(status), 64'h1);
        fire = 8'h01; clr_we = 1'b1; clr = 8'h01;
        tick();
        fire = '0; clr_we = 1'b0; clr = '0;
        chk("R8 status", 64'(status), 64'h0);
        chk("R8 lines", 64'(lines), 64'h0);

        // R9: clear only the bits written as 1
        wcfg(1, mk(0, 1, 1, 5'd22));
        pulse_fire(8'h03);
        chk("R9 both held", 64'(status), 64'h3);
        wclr(8'h05);
        chk("R9 status", 64'(status), 64'h2);
        chk("R9 lines", 64'(lines), 64'(32'h1 << 22));
        wclr('1);

        // R10: reconfiguration of a held level
        pulse_fire(8'h01);
        wcfg(0, mk(0, 1, 1, 5'd21));
        chk("R10 same word keeps", 64'(status), 64'h1);
        wcfg(0, mk(0, 1, 1, 5'd22));
        chk("R10 route move status", 64'(status), 64'h0);
        chk("R10 route move lines", 64'(lines), 64'h0);
        wcfg(0, mk(0, 1, 1, 5'd21));
        pulse_fire(8'h01);
        wcfg(0, mk(0, 1, 0, 5'd21));
        chk("R10 to edge", 64'(status), 64'h0);
        wcfg(0, mk(0, 1, 1, 5'd21));
        pulse_fire(8'h01);
        wcfg(0, mk(0, 0, 1, 5'd21));
        chk("R10 disable", 64'(status), 64'h0);
        wcfg(0, mk(0, 1, 1, 5'd21));
        pulse_fire(8'h01);
        wcfg(0, mk(1, 1, 1, 5'd21));
        chk("R10 to message", 64'(status), 64'h0);
        tick();
        chk("R10 no message", 64'(mreq), 64'h0);

        // R11: shared line
        wcfg(0, mk(0, 1, 1, 5'd21));
        wcfg(1, mk(0, 1, 1, 5'd21));
        pulse_fire(8'h03);
        wclr(8'h01);
        chk("R11 line stays", 64'(lines), 64'(32'h1 << 21));
        wclr(8'h02);
        chk("R11 line drops", 64'(lines), 64'h0);

        // R3: two messages in the same cycle
        wcfg(0, mk(1, 1, 0, 5'd0));
        wcfg(2, mk(1, 1, 0, 5'd0));
        pulse_fire(8'h05);
        tick();
        chk("R3 first req", 64'(mreq), 64'h1);
        chk("R3 first addr", 64'(maddr), 64'hfee0_1000);
        tick();
        chk("R3 second req", 64'(mreq), 64'h1);
        chk("R3 second data", 64'(mdata), 64'h52);
        tick();
        chk("R3 idle", 64'(mreq), 64'h0);

        // R5: wide line count permits 24..31 only
        wcfg(0, mk(0, 1, 1, 5'd24));
        pulse_fire(8'h01);
        chk("R5 wide line 24", 64'(w_lines), 64'(32'h1 << 24));
        chk("R5 narrow rejects 24", 64'(lines), 64'h0);
        wclr('1);
        wcfg(0, mk(0, 1, 1, 5'd23));
        pulse_fire(8'h01);
        chk("R5 wide rejects 23", 64'(w_lines), 64'h0);
        chk("R5 narrow line 23", 64'(lines), 64'(32'h1 << 23));
        wclr('1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule